// File: doc/BRIEF.md
# I/O Interrupt Message Generator

This block gathers 24 interrupt input pins and turns them into memory-write messages aimed at the processor. No acknowledge cycle is involved. Software programs one redirection entry per pin. Each entry holds a delivery vector, a priority, a trigger mode, a polarity and a mask. A separate register holds the identifier of this controller, which is placed in every message address so that several controllers can share one system.

An input in edge mode records a pending request on its active transition. An input in level mode requests delivery for as long as it is active. After a level source has been delivered, it is not sent again until an end-of-interrupt carrying its vector arrives. When several requests compete, the entry with the largest priority value is sent first, whatever its pin number.

Messages leave through a valid/ready write port. The address and vector are held steady until the receiver accepts them.

Top module: `irq_msg_gen`

## Requirements
- R1: After reset every entry is masked, so no message is produced whatever the input pins do.
- R2: The redirection entry is 15 bits wide, with the following layout: bits [7:0] vector, [11:8] priority, bit 12 level mode (1 = level, 0 = edge), bit 13 active-low (1 = active low), bit 14 mask (1 = masked). An unmasked edge-mode input that goes active produces exactly one message carrying its vector.
- R3: With the active-low bit set, a falling pin is the active transition and a rising pin produces nothing.
- R4: An unmasked level-mode input produces a message while it is active. After acceptance it is not resent until an end-of-interrupt with a matching vector arrives. An end-of-interrupt with any other vector has no effect. If the input is still active after the matching end-of-interrupt, the message is sent again.
- R5: Among competing requests, the largest priority value is sent first. On a tie, the lower input index wins.
- R6: The message address is {12'hFEE, identifier[7:0], 12'h000}, where the identifier is the value last written through the identifier port.
- R7: While valid is high and ready is low, valid, address and vector stay unchanged. In the cycle after acceptance, valid is low.
- R8: An entry whose vector is below 0x10 is never delivered. A vector of exactly 0x10 is delivered.
- R9: An edge that arrives while its entry is masked is dropped. Unmasking the entry later produces no message.
- R10: Configuration writes to indices 24 to 31 change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 24 | Interrupt input pins |
| cfg_we | input | 1 | Redirection entry write strobe |
| cfg_idx | input | 5 | Entry index to write |
| cfg_entry | input | 15 | Entry value to write |
| id_we | input | 1 | Identifier write strobe |
| id_value | input | 8 | Identifier value |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 32 | Message write address |
| msg_vector | output | 8 | Message data: the vector |

## Verification
A pin change that is present at a rising edge raises msg_valid after the next rising edge, two edges in all. This holds for both edge and level inputs. A matching end-of-interrupt on a still-active level source brings the message back one edge after the edge that retires it. Valid falls at the accepting edge, and the next queued message appears one edge later. The bench drives every input on falling edges and samples on the falling edge reached after exactly that number of rising edges. Checks for absence wait several further edges, so that a late message would still be caught.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
    localparam int NUM_IRQ = 24;
    localparam int VEC_W   = 8;
    localparam int PRI_W   = 4;
    localparam int ID_W    = 8;
    localparam logic [VEC_W-1:0] MIN_VEC  = 8'h10;
    localparam logic [11:0]      MSG_BASE = 12'hFEE;

    // msb first: mask, active-low, level, priority, vector
    typedef struct packed {
        logic             mask;
        logic             low_act;
        logic             level;
        logic [PRI_W-1:0] prio;
        logic [VEC_W-1:0] vec;
    } redir_t;

    localparam int ENTRY_W = $bits(redir_t);

    typedef enum logic {S_IDLE, S_SEND} send_st_t;

    function automatic logic vec_legal(input logic [VEC_W-1:0] v);
        return v >= MIN_VEC;
    endfunction

    function automatic logic [31:0] msg_address(input logic [ID_W-1:0] id);
        return {MSG_BASE, id, 12'h000};
    endfunction
endpackage

// File: rtl/irq_redir_table.sv
module irq_redir_table import irq_msg_pkg::*; #(
    parameter int NUM_IN = 24,
    parameter int IDX_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  redir_t                  wr_val,
    output redir_t [NUM_IN-1:0]     table_q
);
    localparam redir_t RST_ENTRY = '{mask: 1'b1, low_act: 1'b0, level: 1'b0,
                                     prio: '0, vec: '0};

    for (genvar g = 0; g < NUM_IN; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                table_q[g] <= RST_ENTRY;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                table_q[g] <= wr_val;
            end
        end
    end
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit import irq_msg_pkg::*; #(
    parameter int NUM_IN = 24,
    parameter int IDX_W  = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_IN-1:0]             pins,
    input  logic [NUM_IN-1:0]             f_mask,
    input  logic [NUM_IN-1:0]             f_low,
    input  logic [NUM_IN-1:0]             f_lvl,
    input  logic [NUM_IN-1:0][VEC_W-1:0]  f_vec,
    input  logic                          done_valid,
    input  logic [IDX_W-1:0]              done_idx,
    input  logic                          eoi_valid,
    input  logic [VEC_W-1:0]              eoi_vec,
    output logic [NUM_IN-1:0]             req
);
    for (genvar g = 0; g < NUM_IN; g++) begin : g_src
        logic act, act_q, pend_q, insvc_q, ok, done_me, edge_hit;

        assign act      = pins[g] ^ f_low[g];
        assign ok       = !f_mask[g] && vec_legal(f_vec[g]);
        assign done_me  = done_valid && done_idx == IDX_W'(g);
        assign edge_hit = !f_lvl[g] && ok && act && !act_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                act_q   <= 1'b0;
                pend_q  <= 1'b0;
                insvc_q <= 1'b0;
            end else begin
                act_q <= act;
                // a fresh edge outranks the retirement of the previous one
                if (edge_hit)     pend_q <= 1'b1;
                else if (done_me) pend_q <= 1'b0;
                if (done_me && f_lvl[g])
                    insvc_q <= 1'b1;
                else if (eoi_valid && eoi_vec == f_vec[g])
                    insvc_q <= 1'b0;
            end
        end

        assign req[g] = ok && (f_lvl[g] ? (act_q && !insvc_q) : pend_q);
    end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb import irq_msg_pkg::*; #(
    parameter int NUM_IN = 24,
    parameter int IDX_W  = 5
) (
    input  logic [NUM_IN-1:0]             req,
    input  logic [NUM_IN-1:0][PRI_W-1:0]  f_pri,
    output logic                          any,
    output logic [IDX_W-1:0]              win_idx
);
    logic [PRI_W-1:0] best;

    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        best    = '0;
        // ascending scan with strict compare keeps the lower index on ties
        for (int i = 0; i < NUM_IN; i++) begin
            if (req[i] && (!any || f_pri[i] > best)) begin
                any     = 1'b1;
                win_idx = IDX_W'(i);
                best    = f_pri[i];
            end
        end
    end
endmodule

// File: rtl/irq_msg_gen.sv
module irq_msg_gen import irq_msg_pkg::*; #(
    parameter int NUM_IN = NUM_IRQ,
    localparam int IDX_W = $clog2(NUM_IN)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_IN-1:0]   irq_in,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [ENTRY_W-1:0]  cfg_entry,
    input  logic                id_we,
    input  logic [ID_W-1:0]     id_value,
    input  logic                eoi_valid,
    input  logic [VEC_W-1:0]    eoi_vector,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [31:0]         msg_addr,
    output logic [VEC_W-1:0]    msg_vector
);
    redir_t [NUM_IN-1:0]            tbl;
    logic [NUM_IN-1:0]              f_mask, f_low, f_lvl, req;
    logic [NUM_IN-1:0][VEC_W-1:0]   f_vec;
    logic [NUM_IN-1:0][PRI_W-1:0]   f_pri;
    logic                           any, accept;
    logic [IDX_W-1:0]               win_idx, src_q;
    logic [ID_W-1:0]                id_q;
    logic [31:0]                    addr_q;
    logic [VEC_W-1:0]               vec_q;
    send_st_t                       st_q;

    irq_redir_table #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_val (redir_t'(cfg_entry)),
        .table_q(tbl)
    );

    for (genvar g = 0; g < NUM_IN; g++) begin : g_fields
        assign f_mask[g] = tbl[g].mask;
        assign f_low[g]  = tbl[g].low_act;
        assign f_lvl[g]  = tbl[g].level;
        assign f_vec[g]  = tbl[g].vec;
        assign f_pri[g]  = tbl[g].prio;
    end

    assign accept = (st_q == S_SEND) && msg_ready;

    irq_pend_unit #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .pins      (irq_in),
        .f_mask    (f_mask),
        .f_low     (f_low),
        .f_lvl     (f_lvl),
        .f_vec     (f_vec),
        .done_valid(accept),
        .done_idx  (src_q),
        .eoi_valid (eoi_valid),
        .eoi_vec   (eoi_vector),
        .req       (req)
    );

    irq_prio_arb #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_arb (
        .req    (req),
        .f_pri  (f_pri),
        .any    (any),
        .win_idx(win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            id_q   <= '0;
            src_q  <= '0;
            addr_q <= '0;
            vec_q  <= '0;
        end else begin
            if (id_we) id_q <= id_value;
            case (st_q)
                S_IDLE: if (any) begin
                    st_q   <= S_SEND;
                    src_q  <= win_idx;
                    addr_q <= msg_address(id_q);
                    vec_q  <= f_vec[win_idx];
                end
                S_SEND: if (msg_ready) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign msg_valid  = (st_q == S_SEND);
    assign msg_addr   = addr_q;
    assign msg_vector = vec_q;
endmodule

// File: rtl/irq_msg_gen_chk.sv
module irq_msg_gen_chk import irq_msg_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [31:0]       msg_addr,
    input logic [VEC_W-1:0]  msg_vector
);
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !msg_valid);

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_vector));

    p_gap_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_ready |=> !msg_valid);

    p_legal_vector_r8: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> msg_vector >= MIN_VEC);

    p_addr_form_r6: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_addr[31:20] == MSG_BASE && msg_addr[11:0] == 12'h000));
endmodule

bind irq_msg_gen irq_msg_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_vector(msg_vector)
);

// File: tb/irq_msg_gen_bench.sv
module irq_msg_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] irq_in = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [14:0] cfg_entry = '0;
    logic        id_we = 1'b0;
    logic [7:0]  id_value = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        msg_valid, msg_ready = 1'b0;
    logic [31:0] msg_addr;
    logic [7:0]  msg_vector;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [7:0] cur_id = '0;

    always #4 clk = ~clk;

    irq_msg_gen u_irq_msg_gen (
        .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_entry(cfg_entry), .id_we(id_we), .id_value(id_value),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_vector(msg_vector)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_entry(input int idx, input bit mask, input bit low, input bit lvl,
                            input int pri, input logic [7:0] vec);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = 5'(idx);
        cfg_entry = {mask, low, lvl, 4'(pri), vec};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_id(input logic [7:0] v);
        @(negedge clk);
        id_we = 1'b1; id_value = v;
        @(negedge clk);
        id_we = 1'b0;
        cur_id = v;
    endtask

    // called on a falling edge; returns on the next falling edge with ready low
    task automatic ack();
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic expect_none(input int n, input string tag);
        repeat (n) @(negedge clk);
        chk(msg_valid == 1'b0, tag, 32'(msg_valid), 32'd0);
    endtask

    // pulse one pin high for one cycle starting at a falling edge,
    // return on the falling edge where the message is due
    task automatic pulse(input int i);
        @(negedge clk);
        irq_in[i] = 1'b1;
        @(negedge clk);
        irq_in[i] = 1'b0;
        @(negedge clk);
    endtask

    task automatic pair_case(input int a, input int b, input int pa, input int pb);
        int first, second;
        first  = (pb > pa) ? b : a;
        second = (first == a) ? b : a;
        wr_entry(a, 0, 0, 0, pa, 8'(32 + a));
        wr_entry(b, 0, 0, 0, pb, 8'(32 + b));
        @(negedge clk);
        irq_in[a] = 1'b1; irq_in[b] = 1'b1;
        @(negedge clk);
        irq_in[a] = 1'b0; irq_in[b] = 1'b0;
        @(negedge clk);
        chk(msg_valid && msg_vector == 8'(32 + first), "R5 first winner",
            {23'd0, msg_valid, msg_vector}, {24'd1, 8'(32 + first)});
        ack();
        @(negedge clk);
        chk(msg_valid && msg_vector == 8'(32 + second), "R5 second winner",
            {23'd0, msg_valid, msg_vector}, {24'd1, 8'(32 + second)});
        ack();
        wr_entry(a, 1, 0, 0, 0, 8'h20);
        wr_entry(b, 1, 0, 0, 0, 8'h20);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold_addr;
        logic [7:0]  hold_vec;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(msg_valid == 1'b0, "R1 reset idle", 32'(msg_valid), 0);

        // R1: all pins toggle with reset entries
        irq_in = '1;
        expect_none(4, "R1 masked after reset rise");
        irq_in = '0;
        expect_none(3, "R1 masked after reset fall");

        // R10: writes above the last index touch nothing
        for (int k = 24; k < 32; k++) wr_entry(k, 0, 0, 0, 5, 8'h50);
        @(negedge clk); irq_in = '1;
        @(negedge clk); irq_in = '0;
        expect_none(4, "R10 out-of-range write");

        // R2/R6: edge delivery on every input with changing identifier
        for (int i = 0; i < 24; i++) begin
            set_id(8'(i * 11 + 1));
            wr_entry(i, 0, 0, 0, i % 16, 8'(32 + i));
            pulse(i);
            chk(msg_valid && msg_vector == 8'(32 + i), "R2 edge vector",
                {23'd0, msg_valid, msg_vector}, {24'd1, 8'(32 + i)});
            chk(msg_addr == {12'hFEE, cur_id, 12'h000}, "R6 address",
                msg_addr, {12'hFEE, cur_id, 12'h000});
            ack();
            chk(msg_valid == 1'b0, "R7 gap after accept", 32'(msg_valid), 0);
            expect_none(3, "R2 single message");
            wr_entry(i, 1, 0, 0, 0, 8'(32 + i));
        end

        // R7: hold while not ready
        wr_entry(1, 0, 0, 0, 2, 8'h33);
        pulse(1);
        hold_addr = msg_addr; hold_vec = msg_vector;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(msg_valid && msg_addr == hold_addr && msg_vector == hold_vec,
                "R7 hold stable", {msg_addr[31:8], msg_vector}, {hold_addr[31:8], hold_vec});
        end
        ack();
        chk(msg_valid == 1'b0, "R7 drop after accept", 32'(msg_valid), 0);
        expect_none(3, "R7 no repeat");
        wr_entry(1, 1, 0, 0, 0, 8'h33);

        // R3: active-low polarity
        @(negedge clk); irq_in[6] = 1'b1;
        wr_entry(6, 0, 1, 0, 1, 8'h66);
        expect_none(3, "R3 idle high quiet");
        pulse_low6();
        chk(msg_valid && msg_vector == 8'h66, "R3 falling delivers",
            {23'd0, msg_valid, msg_vector}, 32'h166);
        ack();
        irq_in[6] = 1'b1;
        expect_none(4, "R3 rising quiet");
        wr_entry(6, 1, 0, 0, 0, 8'h66);
        irq_in[6] = 1'b0;

        // R4: level source with end-of-interrupt
        wr_entry(5, 0, 0, 1, 3, 8'h45);
        @(negedge clk); irq_in[5] = 1'b1;
        repeat (2) @(negedge clk);
        chk(msg_valid && msg_vector == 8'h45, "R4 level delivers",
            {23'd0, msg_valid, msg_vector}, 32'h145);
        ack();
        expect_none(4, "R4 in service no resend");
        eoi_valid = 1'b1; eoi_vector = 8'h46;
        @(negedge clk); eoi_valid = 1'b0;
        expect_none(3, "R4 wrong eoi ignored");
        eoi_valid = 1'b1; eoi_vector = 8'h45;
        @(negedge clk); eoi_valid = 1'b0;
        @(negedge clk);
        chk(msg_valid && msg_vector == 8'h45, "R4 resend after eoi",
            {23'd0, msg_valid, msg_vector}, 32'h145);
        ack();
        irq_in[5] = 1'b0;
        repeat (2) @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = 8'h45;
        @(negedge clk); eoi_valid = 1'b0;
        expect_none(3, "R4 inactive after eoi");
        wr_entry(5, 1, 0, 0, 0, 8'h45);

        // R8: illegal vectors
        wr_entry(2, 0, 0, 0, 4, 8'h0F);
        pulse(2);
        expect_none(2, "R8 vector 0x0F blocked");
        wr_entry(2, 0, 0, 0, 4, 8'h10);
        pulse(2);
        chk(msg_valid && msg_vector == 8'h10, "R8 vector 0x10 delivered",
            {23'd0, msg_valid, msg_vector}, 32'h110);
        ack();
        wr_entry(2, 0, 0, 1, 4, 8'h00);
        @(negedge clk); irq_in[2] = 1'b1;
        expect_none(4, "R8 level vector 0x00 blocked");
        irq_in[2] = 1'b0;
        wr_entry(2, 1, 0, 0, 0, 8'h10);

        // R9: edge while masked is dropped
        wr_entry(8, 1, 0, 0, 6, 8'h88);
        pulse(8);
        wr_entry(8, 0, 0, 0, 6, 8'h88);
        expect_none(3, "R9 masked edge dropped");
        pulse(8);
        chk(msg_valid && msg_vector == 8'h88, "R9 unmasked edge delivered",
            {23'd0, msg_valid, msg_vector}, 32'h188);
        ack();
        wr_entry(8, 1, 0, 0, 0, 8'h88);

        // R5: priority independent of index, then sweep of all pairs
        pair_case(3, 10, 2, 9);
        pair_case(4, 7, 5, 5);
        for (int a = 0; a < 24; a++)
            for (int b = a + 1; b < 24; b++)
                pair_case(a, b, (a * 5) % 16, (b * 7 + 3) % 16);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // R3 helper: pin 6 falls at a falling edge, message due two edges later
    task automatic pulse_low6();
        @(negedge clk);
        irq_in[6] = 1'b0;
        repeat (2) @(negedge clk);
    endtask
endmodule